// File: doc/BRIEF.md
# AC-link command frame serializer

This block is the transmit half of the controller end of an AC'97-style serial link. It runs on the bit clock, starts a new output frame every 256 bit times, and drives the frame marker (`sync_o`) and the serial data line (`sdata_o`). It builds only the command part of each frame: the tag slot, the command address slot and the command data slot. The ten audio slots that follow are always sent as zeros.

A requester presents a register access on a level-held request: a read/write flag, a 7-bit register index and 16 bits of write data. The block looks at the request only at the frame boundary. If a request is waiting there, it is placed into the frame that starts on that edge, and `req_accept` pulses for one cycle. The requester then drops or changes its request. Each bit is launched on a rising bit-clock edge so that the codec can sample it on the next falling edge. The first data bit trails the rising edge of the frame marker by one bit time.

Top module: `aclink_cmd_tx`

## Requirements
- R1: While `rst` is high, `sync_o`, `sdata_o` and `req_accept` are low. The first frame marker rises in the first clock cycle after `rst` is released.
- R2: Consecutive rising edges of `sync_o` are exactly 256 clock cycles apart (a 16-bit tag slot plus twelve 20-bit slots).
- R3: `sync_o` stays high for exactly 16 cycles from each rising edge and is low for the rest of the frame.
- R4: Frame bit k (k = 0 to 255, where bit 0 is the top bit of the tag slot and bits run MSB first through each slot) is on `sdata_o` in the cycle k+1 cycles after the one in which `sync_o` rises. `sdata_o` is low in the rising cycle itself.
- R5: Tag slot. Bit 15 (frame valid) and bit 14 (address slot valid) are 1 exactly when a command was accepted for the frame. Bit 13 (data slot valid) is 1 only for an accepted write. Bits 12:0 are always 0.
- R6: Address slot (frame bits 16 to 35). Bit 19 is the read flag (1 = read, 0 = write). Bits 18:12 carry the register index with its MSB in bit 18. Bits 11:0 are 0. The whole slot is 0 when no command was accepted.
- R7: Data slot (frame bits 36 to 55). For a write, bits 19:4 carry the write data with D15 in bit 19, sent in the same frame as its address. Bits 3:0 are 0. For a read, or when idle, the whole slot is 0 whatever the value on `req_wdata`.
- R8: Frame bits 56 to 255 (audio slots 3 to 12) are always 0.
- R9: The request inputs are sampled only on the clock edge that raises `sync_o`. `req_accept` is high for exactly that one cycle when a request was pending, and a request held across other edges waits for the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A register command is pending |
| req_read | input | 1 | 1 = read command, 0 = write command |
| req_index | input | 7 | Register index |
| req_wdata | input | 16 | Write data (ignored on reads) |
| req_accept | output | 1 | One-cycle pulse: command placed into the frame now starting |
| sync_o | output | 1 | Frame marker, high during the tag slot |
| sdata_o | output | 1 | Serial output data, MSB first |

## Verification
A fault in the bit counter appears at once as a frame marker of the wrong length or spacing. A fault in the shift register or the slot image shows up on the data line within the first 57 bit times of the next frame, as a misplaced tag, index or data bit. If the request is captured on the wrong edge, `req_accept` leaves the marker's rising cycle and the command moves to a different frame. The bench compares all three outputs against its own model in every cycle. So any such fault is reported in the frame where it first appears.

// File: rtl/aclink_pkg.sv
package aclink_pkg;

  // Phase of the next bit time, decoded from the frame counter.
  typedef enum logic [1:0] {
    PH_LOAD  = 2'd0,  // frame boundary: capture request, load slot image
    PH_SHIFT = 2'd1,  // command bits leave the shift register
    PH_IDLE  = 2'd2   // audio slots: line held low
  } tx_phase_e;

endpackage

// File: rtl/aclink_frame_timer.sv
module aclink_frame_timer
  import aclink_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int SYNC_BITS  = 16,
  parameter int CMD_BITS   = 56
) (
  input  logic      clk,
  input  logic      rst,
  output logic      sync_o,
  output tx_phase_e phase_o
);

  localparam int CNT_W = $clog2(FRAME_BITS);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_n;
  logic             sync_q;

  // The counter value after this edge selects what the outputs show next.
  always_comb begin
    if (cnt_q == CNT_W'(FRAME_BITS - 1)) cnt_n = '0;
    else                                 cnt_n = cnt_q + 1'b1;
  end

  always_comb begin
    if (cnt_n == '0)                          phase_o = PH_LOAD;
    else if (cnt_n <= CNT_W'(CMD_BITS))       phase_o = PH_SHIFT;
    else                                      phase_o = PH_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= CNT_W'(FRAME_BITS - 1);
      sync_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      sync_q <= (cnt_n < CNT_W'(SYNC_BITS));
    end
  end

  assign sync_o = sync_q;

endmodule

// File: rtl/aclink_cmd_builder.sv
module aclink_cmd_builder #(
  parameter int TAG_W  = 16,
  parameter int SLOT_W = 20,
  parameter int IDX_W  = 7,
  parameter int DATA_W = 16,
  localparam int IMG_W = TAG_W + 2 * SLOT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              req_valid,
  input  logic              req_read,
  input  logic [IDX_W-1:0]  req_index,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [IMG_W-1:0]  image_o,
  output logic              accept_o
);

  logic [TAG_W-1:0]  tag;
  logic [SLOT_W-1:0] addr_slot;
  logic [SLOT_W-1:0] data_slot;
  logic              accept_q;

  // Reserved fields stay at the zero default; only live fields are written.
  always_comb begin
    tag       = '0;
    addr_slot = '0;
    data_slot = '0;
    if (req_valid) begin
      tag[TAG_W-1] = 1'b1;                       // frame valid
      tag[TAG_W-2] = 1'b1;                       // address slot valid
      tag[TAG_W-3] = ~req_read;                  // data slot valid on writes
      addr_slot[SLOT_W-1]           = req_read;
      addr_slot[SLOT_W-2 -: IDX_W]  = req_index;
      if (!req_read) data_slot[SLOT_W-1 -: DATA_W] = req_wdata;
    end
  end

  assign image_o = {tag, addr_slot, data_slot};

  always_ff @(posedge clk) begin
    if (rst) accept_q <= 1'b0;
    else     accept_q <= load & req_valid;
  end

  assign accept_o = accept_q;

endmodule

// File: rtl/aclink_slot_shifter.sv
module aclink_slot_shifter
  import aclink_pkg::*;
#(
  parameter int IMG_W = 56
) (
  input  logic             clk,
  input  logic             rst,
  input  tx_phase_e        phase,
  input  logic [IMG_W-1:0] image,
  output logic             sdata_o
);

  logic [IMG_W-1:0] shreg_q;
  logic             sdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '0;
      sdata_q <= 1'b0;
    end else begin
      case (phase)
        PH_LOAD: begin
          shreg_q <= image;
          sdata_q <= 1'b0;
        end
        PH_SHIFT: begin
          sdata_q <= shreg_q[IMG_W-1];
          shreg_q <= {shreg_q[IMG_W-2:0], 1'b0};
        end
        default: begin
          sdata_q <= 1'b0;
        end
      endcase
    end
  end

  assign sdata_o = sdata_q;

endmodule

// File: rtl/aclink_cmd_tx.sv
module aclink_cmd_tx
  import aclink_pkg::*;
#(
  parameter int TAG_W     = 16,
  parameter int SLOT_W    = 20,
  parameter int NUM_SLOTS = 12,
  parameter int IDX_W     = 7,
  parameter int DATA_W    = 16
) (
  input  logic              bit_clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_read,
  input  logic [IDX_W-1:0]  req_index,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_accept,
  output logic              sync_o,
  output logic              sdata_o
);

  localparam int FRAME_BITS = TAG_W + NUM_SLOTS * SLOT_W;
  localparam int CMD_BITS   = TAG_W + 2 * SLOT_W;

  tx_phase_e            phase;
  logic                 load_en;
  logic [CMD_BITS-1:0]  image;

  assign load_en = (phase == PH_LOAD);

  aclink_frame_timer #(
    .FRAME_BITS (FRAME_BITS),
    .SYNC_BITS  (TAG_W),
    .CMD_BITS   (CMD_BITS)
  ) u_timer (
    .clk     (bit_clk),
    .rst     (rst),
    .sync_o  (sync_o),
    .phase_o (phase)
  );

  aclink_cmd_builder #(
    .TAG_W  (TAG_W),
    .SLOT_W (SLOT_W),
    .IDX_W  (IDX_W),
    .DATA_W (DATA_W)
  ) u_builder (
    .clk       (bit_clk),
    .rst       (rst),
    .load      (load_en),
    .req_valid (req_valid),
    .req_read  (req_read),
    .req_index (req_index),
    .req_wdata (req_wdata),
    .image_o   (image),
    .accept_o  (req_accept)
  );

  aclink_slot_shifter #(
    .IMG_W (CMD_BITS)
  ) u_shifter (
    .clk     (bit_clk),
    .rst     (rst),
    .phase   (phase),
    .image   (image),
    .sdata_o (sdata_o)
  );

endmodule

// File: rtl/aclink_cmd_tx_chk.sv
module aclink_cmd_tx_chk #(
  parameter int SYNC_BITS  = 16,
  parameter int CMD_BITS   = 56,
  parameter int FRAME_BITS = 256
) (
  input logic clk,
  input logic rst,
  input logic sync_o,
  input logic sdata_o,
  input logic req_accept
);

  localparam int PW = $clog2(FRAME_BITS) + 2;

  logic [PW-1:0] ck_pos_q;
  logic [PW-1:0] pos;
  logic          sync_prev_q;
  logic          seen_q;
  logic          rise;

  // Position inside the frame, measured independently from the marker.
  assign rise = sync_o & ~sync_prev_q;
  assign pos  = rise ? '0 : ck_pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_pos_q    <= '0;
      sync_prev_q <= 1'b0;
      seen_q      <= 1'b0;
    end else begin
      sync_prev_q <= sync_o;
      if (rise) seen_q <= 1'b1;
      if (pos != '1) ck_pos_q <= pos + 1'b1;
    end
  end

  // R2: marker period
  a_r2_frame_period: assert property (@(posedge clk) disable iff (rst)
    (rise && seen_q) |-> (ck_pos_q == PW'(FRAME_BITS)))
    else $error("R2 frame period wrong");

  // R3: marker width
  a_r3_sync_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(sync_o) |-> (ck_pos_q == PW'(SYNC_BITS)))
    else $error("R3 marker fell at wrong time");

  a_r3_sync_bound: assert property (@(posedge clk) disable iff (rst)
    sync_o |-> (pos < PW'(SYNC_BITS)))
    else $error("R3 marker too long");

  // R9: accept only in the marker's first cycle
  a_r9_accept_on_rise: assert property (@(posedge clk) disable iff (rst)
    req_accept |-> rise)
    else $error("R9 accept off the boundary");

  // R5: frame valid and address tag follow acceptance
  a_r5_valid_frame: assert property (@(posedge clk) disable iff (rst)
    (seen_q && pos == PW'(1)) |-> (sdata_o == $past(req_accept)))
    else $error("R5 frame valid tag wrong");

  a_r5_addr_tag: assert property (@(posedge clk) disable iff (rst)
    (seen_q && pos == PW'(2)) |-> (sdata_o == $past(req_accept, 2)))
    else $error("R5 address tag wrong");

  a_r5_tag_reserved: assert property (@(posedge clk) disable iff (rst)
    (seen_q && pos >= PW'(4) && pos <= PW'(SYNC_BITS)) |-> !sdata_o)
    else $error("R5 reserved tag bit set");

  // R8: audio slots and the boundary cycle are silent
  a_r8_tail_zero: assert property (@(posedge clk) disable iff (rst)
    (rise || (seen_q && pos > PW'(CMD_BITS))) |-> !sdata_o)
    else $error("R8 audio slot not zero");

endmodule

bind aclink_cmd_tx aclink_cmd_tx_chk #(
  .SYNC_BITS  (TAG_W),
  .CMD_BITS   (TAG_W + 2 * SLOT_W),
  .FRAME_BITS (TAG_W + NUM_SLOTS * SLOT_W)
) u_chk (
  .clk        (bit_clk),
  .rst        (rst),
  .sync_o     (sync_o),
  .sdata_o    (sdata_o),
  .req_accept (req_accept)
);

// File: tb/test_aclink_cmd_tx.sv
module test_aclink_cmd_tx;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        req_read;
  logic [6:0]  req_index;
  logic [15:0] req_wdata;
  logic        req_accept;
  logic        sync_o;
  logic        sdata_o;

  always #4 clk = ~clk;  // 125 MHz

  aclink_cmd_tx i_aclink_cmd_tx (
    .bit_clk    (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_read   (req_read),
    .req_index  (req_index),
    .req_wdata  (req_wdata),
    .req_accept (req_accept),
    .sync_o     (sync_o),
    .sdata_o    (sdata_o)
  );

  int         n_cmp = 0;
  int         n_bad = 0;
  int         mpos = -1;
  int         frame_no = -1;
  bit [255:0] exp_frame = '0;
  bit         exp_acc = 1'b0;
  int         cyc = 0;
  int         last_rise = -1;
  logic       prev_sync = 1'b0;
  bit         done = 1'b0;

  task automatic chk(string tag, logic act, logic exp, string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b (frame %0d pos %0d)",
               tag, what, act, exp, frame_no, mpos);
    end
  endtask

  // Reference model: frame position and expected frame content.
  always @(posedge clk) begin
    if (rst) begin
      mpos = -1;
    end else begin
      mpos = (mpos + 1) % 256;
      if (mpos == 0) begin
        frame_no++;
        exp_frame = '0;
        exp_acc   = req_valid;
        if (req_valid) begin
          exp_frame[0] = 1'b1;
          exp_frame[1] = 1'b1;
          exp_frame[2] = ~req_read;
          exp_frame[16] = req_read;
          for (int i = 0; i < 7; i++) exp_frame[17 + i] = req_index[6 - i];
          if (!req_read)
            for (int i = 0; i < 16; i++) exp_frame[36 + i] = req_wdata[15 - i];
        end
      end
    end
  end

  function automatic string data_tag(int k);
    if (k < 0)       return "R8";
    else if (k == 0) return "R4";
    else if (k < 16) return "R5";
    else if (k < 36) return "R6";
    else if (k < 56) return "R7";
    else             return "R8";
  endfunction

  // Compare away from the active edge.
  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      chk("R1", sync_o, 1'b0, "sync in reset");
      chk("R1", sdata_o, 1'b0, "sdata in reset");
      chk("R1", req_accept, 1'b0, "accept in reset");
    end else if (mpos >= 0) begin
      if (frame_no == 0 && mpos == 0) chk("R1", sync_o, 1'b1, "first marker");
      else chk("R3", sync_o, (mpos < 16), "marker level");
      chk(data_tag(mpos - 1), sdata_o,
          (mpos >= 1) ? exp_frame[mpos - 1] : 1'b0, "serial bit");
      chk("R9", req_accept, (mpos == 0) && exp_acc, "accept pulse");
      if (sync_o && !prev_sync) begin
        if (last_rise >= 0) begin
          n_cmp++;
          if (cyc - last_rise != 256) begin
            n_bad++;
            $display("FAIL R2 period: actual %0d expected 256", cyc - last_rise);
          end
        end
        last_rise = cyc;
      end
    end
    prev_sync = sync_o;
  end

  task automatic issue(logic rd, logic [6:0] idx, logic [15:0] wd);
    req_valid = 1'b1;
    req_read  = rd;
    req_index = idx;
    req_wdata = wd;
    forever begin
      @(negedge clk);
      if (req_accept) break;
    end
    req_valid = 1'b0;
    req_read  = ~rd;
    req_index = 7'h55;
    req_wdata = 16'h3C3C;
  endtask

  initial begin
    rst = 1'b1;
    req_valid = 1'b0;
    req_read  = 1'b0;
    req_index = '0;
    req_wdata = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (300) @(negedge clk);            // idle frames: all-zero content
    issue(1'b0, 7'h02, 16'h8000);           // write, lone MSB of data
    repeat (37) @(negedge clk);             // request raised mid-frame (R9)
    issue(1'b1, 7'h7F, 16'hFFFF);           // read: wdata must be dropped (R7)
    issue(1'b0, 7'h7F, 16'hFFFF);           // all-ones write
    issue(1'b0, 7'h00, 16'h0001);           // lowest data bit, index zero
    issue(1'b1, 7'h40, 16'h0000);           // back-to-back read
    issue(1'b0, 7'h2A, 16'hA5C3);
    repeat (100) @(negedge clk);
    issue(1'b1, 7'h01, 16'h1234);
    repeat (600) @(negedge clk);            // let last frame and idle frames pass
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule